// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a logical address, given as a segment number and an offset within that segment, into a physical address. Every process owns a table of segment descriptors held in ordinary memory. A table-address input gives the start of that table, and a table-size input gives the number of descriptors in it. Each descriptor records where the segment starts in physical memory, how long it is, whether it may be used at all, and which kinds of access it allows.

A CPU request carries a segment number, an offset and an access kind (read, write or fetch for execution). The unit first compares the segment number with the table size. It reads the descriptor through a single memory read port only when the segment number is in range, taking two 32-bit words one after the other. It then checks the descriptor's usable flag, the permission for the requested access kind, and the offset against the segment length. A request that passes every check gets back the segment start plus the offset. A request that fails gets a trap flag and a code naming the first check that failed. Only one request is in flight at a time.

Top module: `seg_xlate`

## Requirements
- R1: While reset is active and in the first cycle after it, req_ready is 1 and both rsp_valid and mem_rd_en are 0.
- R2: A request whose segment number is greater than or equal to tbl_len is answered in the cycle right after acceptance with rsp_trap=1, rsp_cause=1 and rsp_paddr=0. mem_rd_en stays 0 for the whole request.
- R3: For an in-range segment s, the unit reads descriptor word 0 at tbl_base+8*s and then word 1 at tbl_base+8*s+4. For each word, mem_rd_en stays high with a constant address until a cycle in which mem_rd_valid is 1, and mem_rd_data is taken in that cycle.
- R4: When bit 31 of word 1 (usable flag) is 0, the answer is cause 2, whatever the permission and length fields hold.
- R5: Permission bits in word 1 are bit 30 for read, bit 29 for write and bit 28 for execute. req_acc encodes 0 as read, 1 as write, 2 as execute, and 3, which no bit grants. A usable segment whose bit for the requested kind is 0 answers cause 3, even if the offset is also out of range.
- R6: Word 1 bits 19:0 hold the segment length. An offset greater than or equal to the length answers cause 4. An offset one below the length passes, and a length of 0 rejects every offset.
- R7: A request that passes all checks answers rsp_trap=0, rsp_cause=0 and rsp_paddr equal to word 0 plus the offset, modulo 2^32.
- R8: rsp_valid is high for exactly one cycle, the cycle after the second descriptor word is taken. req_ready is low from acceptance through that cycle and returns high in the next cycle.

Valid cause codes are 0 (no trap) through 4. The checks are applied in the order segment number, usable flag, permission, length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle; a request is accepted when req_valid is also high |
| req_seg | input | SEG_W | Segment number |
| req_off | input | LIM_W | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 no permission |
| tbl_base | input | 32 | Byte address of the descriptor table |
| tbl_len | input | SEG_W+1 | Number of descriptors in the table |
| mem_rd_en | output | 1 | Descriptor read request, held until served |
| mem_rd_addr | output | 32 | Byte address of the descriptor word being read |
| mem_rd_valid | input | 1 | Read data present on mem_rd_data |
| mem_rd_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_trap | output | 1 | Request rejected |
| rsp_cause | output | 3 | Trap code: 0 none, 1 segment out of range, 2 unusable, 3 permission, 4 length |
| rsp_paddr | output | 32 | Physical address; 0 when the request traps |

## Verification
The bench targets the edges of the segment-number test: a segment equal to the table size, the top segment number, and a table size of zero. A design with an off-by-one there would either read memory past the table or reject the last real descriptor. On the length check it uses an offset one below the length, an offset equal to the length, and a zero length, which expose a less-or-equal comparison. Descriptors that fail several checks at once show whether the cause codes follow the required priority. A base near the top of memory shows whether the add wraps. Read latencies of zero to three cycles show whether the unit takes data without mem_rd_valid or moves its address before the data arrives.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 8,
  parameter int LIM_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SEG_W-1:0]   req_seg,
  input  logic [LIM_W-1:0]   req_off,
  input  logic [1:0]         req_acc,
  input  logic [31:0]        tbl_base,
  input  logic [SEG_W:0]     tbl_len,
  output logic               mem_rd_en,
  output logic [31:0]        mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [31:0]        mem_rd_data,
  output logic               rsp_valid,
  output logic               rsp_trap,
  output logic [2:0]         rsp_cause,
  output logic [31:0]        rsp_paddr
);
  localparam int PAD_W = 32 - SEG_W - 3;
  localparam int OFF_PAD = 32 - LIM_W;

  typedef enum logic [1:0] {S_IDLE, S_RD0, S_RD1, S_RESP} state_t;

  state_t            state;
  logic [LIM_W-1:0]  off_q;
  logic [1:0]        acc_q;
  logic [31:0]       addr_q;
  logic [31:0]       base_q;
  logic [2:0]        cause_q;
  logic [31:0]       paddr_q;

  logic              accept, seg_bad, right_ok, len_ok;
  logic [2:0]        cause_d;

  assign req_ready   = (state == S_IDLE);
  assign accept      = req_valid && req_ready;
  assign seg_bad     = {1'b0, req_seg} >= tbl_len;
  assign mem_rd_en   = (state == S_RD0) || (state == S_RD1);
  assign mem_rd_addr = addr_q;
  assign rsp_valid   = (state == S_RESP);
  assign rsp_cause   = rsp_valid ? cause_q : 3'd0;
  assign rsp_trap    = rsp_valid && (cause_q != 3'd0);
  assign rsp_paddr   = rsp_valid ? paddr_q : 32'd0;

  always_comb begin
    case (acc_q)
      2'd0:    right_ok = mem_rd_data[30];
      2'd1:    right_ok = mem_rd_data[29];
      2'd2:    right_ok = mem_rd_data[28];
      default: right_ok = 1'b0;
    endcase
  end

  assign len_ok  = off_q < mem_rd_data[LIM_W-1:0];
  assign cause_d = !mem_rd_data[31] ? 3'd2 :
                   !right_ok        ? 3'd3 :
                   !len_ok          ? 3'd4 : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      off_q   <= '0;
      acc_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      cause_q <= '0;
      paddr_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          off_q  <= req_off;
          acc_q  <= req_acc;
          addr_q <= tbl_base + {{PAD_W{1'b0}}, req_seg, 3'b000};
          if (seg_bad) begin
            cause_q <= 3'd1;
            paddr_q <= '0;
            state   <= S_RESP;
          end else begin
            state <= S_RD0;
          end
        end
        S_RD0: if (mem_rd_valid) begin
          base_q <= mem_rd_data;
          addr_q <= addr_q + 32'd4;
          state  <= S_RD1;
        end
        S_RD1: if (mem_rd_valid) begin
          cause_q <= cause_d;
          paddr_q <= (cause_d == 3'd0) ? base_q + {{OFF_PAD{1'b0}}, off_q} : 32'd0;
          state   <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic [SEG_W:0]   tbl_len,
  input logic             mem_rd_en,
  input logic [31:0]      mem_rd_addr,
  input logic             mem_rd_valid,
  input logic             rsp_valid,
  input logic             rsp_trap,
  input logic [2:0]       rsp_cause,
  input logic [31:0]      rsp_paddr
);
  AST_BADSEG_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len)) |=> (rsp_valid && rsp_cause == 3'd1)); // R2
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en); // R2
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr))); // R3
  AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cause <= 3'd4)); // R4
  AST_PASS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_trap) |-> (rsp_cause == 3'd0)); // R7
  AST_TRAP_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap) |-> (rsp_paddr == 32'd0)); // R2
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R8
  AST_BUSY_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (!rsp_valid && !req_ready)); // R8
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_seg(req_seg), .tbl_len(tbl_len), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .rsp_valid(rsp_valid),
  .rsp_trap(rsp_trap), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam int SEG_W = 8;
  localparam int LIM_W = 20;
  localparam logic [31:0] TBASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [LIM_W-1:0] req_off = '0;
  logic [1:0] req_acc = '0;
  logic [31:0] tbl_base = TBASE;
  logic [SEG_W:0] tbl_len = 9'd6;
  logic mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic rsp_valid, rsp_trap;
  logic [2:0] rsp_cause;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  logic [31:0] dmem [0:511];

  always #2 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .LIM_W(LIM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .tbl_base(tbl_base), .tbl_len(tbl_len), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic set_desc(input int s, input logic [31:0] base, input bit ok, input logic [2:0] rwx, input logic [19:0] len);
    dmem[2*s]   = base;
    dmem[2*s+1] = {ok, rwx, 8'h00, len};
  endtask

  // Reference model: cause and address from the requirements
  task automatic model(input int s, input int off, input int acc, output int cause, output logic [31:0] pa);
    logic [31:0] w0, w1;
    bit right;
    pa = 32'd0;
    if (s >= int'(tbl_len)) begin cause = 1; return; end
    w0 = dmem[2*s];
    w1 = dmem[2*s+1];
    right = (acc == 0) ? w1[30] : (acc == 1) ? w1[29] : (acc == 2) ? w1[28] : 1'b0;
    if (!w1[31]) cause = 2;
    else if (!right) cause = 3;
    else if (off >= int'(w1[19:0])) cause = 4;
    else begin cause = 0; pa = w0 + 32'(off); end
  endtask

  // Called and returning at a negative edge; compares every cycle
  task automatic do_req(input int s, input int off, input int acc, input int lat, input string rq);
    int cause;
    logic [31:0] pa;
    model(s, off, acc, cause, pa);
    chk(req_ready === 1'b1, "R8 ready before request", 64'(req_ready), 1);
    req_valid = 1'b1;
    req_seg = SEG_W'(s);
    req_off = LIM_W'(off);
    req_acc = 2'(acc);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    req_seg = SEG_W'(s + 1);
    if (cause != 1) begin
      for (int w = 0; w < 2; w++) begin
        for (int c = 0; c <= lat; c++) begin
          chk(mem_rd_en === 1'b1, "R3 read enable", 64'(mem_rd_en), 1);
          chk(mem_rd_addr === TBASE + 32'(8 * s + 4 * w), "R3 read address", 64'(mem_rd_addr), 64'(TBASE + 32'(8 * s + 4 * w)));
          chk(rsp_valid === 1'b0 && req_ready === 1'b0, "R8 busy during fetch", {rsp_valid, req_ready}, 0);
          if (c == lat) begin
            mem_rd_valid = 1'b1;
            mem_rd_data = dmem[2*s+w];
          end else begin
            mem_rd_data = 32'hDEAD_BEEF;
          end
          @(posedge clk); @(negedge clk);
          mem_rd_valid = 1'b0;
        end
      end
    end
    chk(mem_rd_en === 1'b0, {rq, " no read at response"}, 64'(mem_rd_en), 0);
    chk(rsp_valid === 1'b1, {rq, " R8 response strobe"}, 64'(rsp_valid), 1);
    chk(rsp_cause === 3'(cause), {rq, " cause"}, 64'(rsp_cause), 64'(cause));
    chk(rsp_trap === (cause != 0), {rq, " trap"}, 64'(rsp_trap), 64'(cause != 0));
    chk(rsp_paddr === pa, {rq, " paddr"}, 64'(rsp_paddr), 64'(pa));
    @(posedge clk); @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 strobe ends, ready returns", {rsp_valid, req_ready}, 1);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) dmem[i] = 32'h0;
    set_desc(0, 32'h4000_0000, 1'b1, 3'b111, 20'h00100);
    set_desc(1, 32'h8000_0000, 1'b1, 3'b100, 20'h00010);
    set_desc(2, 32'h1234_0000, 1'b0, 3'b000, 20'h00000);
    set_desc(3, 32'h2000_0000, 1'b1, 3'b001, 20'h00000);
    set_desc(4, 32'hFFFF_FF00, 1'b1, 3'b110, 20'hFFFFF);
    set_desc(5, 32'h0000_5000, 1'b1, 3'b111, 20'h00001);
    set_desc(6, 32'h6000_0000, 1'b1, 3'b111, 20'h00100);

    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_en === 1'b0, "R1 in reset", {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_en === 1'b0, "R1 after reset", {req_ready, rsp_valid, mem_rd_en}, 3'b100);

    do_req(0, 'h20, 0, 0, "R7 read pass");
    do_req(0, 'hFF, 2, 2, "R6 offset one below length");
    do_req(0, 'h100, 1, 1, "R6 offset equal to length");
    do_req(1, 'h5, 0, 3, "R7 read-only read");
    do_req(1, 'h5, 1, 0, "R5 write to read-only");
    do_req(1, 'h50, 2, 1, "R5 rights before length");
    do_req(0, 'h10, 3, 0, "R5 access code 3");
    do_req(2, 'h0, 0, 0, "R4 unusable segment");
    do_req(2, 'hFFFFF, 3, 2, "R4 unusable beats other faults");
    do_req(3, 'h0, 2, 0, "R6 zero length");
    do_req(3, 'h0, 0, 1, "R5 read on execute-only");
    do_req(4, 'h1FF, 0, 0, "R7 address wraps");
    do_req(5, 'h0, 1, 0, "R7 one-byte segment");
    do_req(5, 'h1, 1, 2, "R6 past one-byte segment");
    do_req(6, 'h0, 0, 0, "R2 segment equal to size");
    do_req(255, 'h0, 0, 0, "R2 top segment number");
    tbl_len = 9'd7;
    do_req(6, 'h40, 0, 1, "R7 segment after size grows");
    tbl_len = 9'd0;
    do_req(0, 'h0, 0, 0, "R2 empty table");
    tbl_len = 9'd256;
    do_req(255, 'h0, 0, 0, "R4 last segment in full table");
    tbl_base = 32'h0000_2000;
    for (int i = 0; i < 512; i++) dmem[i] = 32'h0;
    set_desc(1, 32'h0001_0000, 1'b1, 3'b010, 20'h00080);
    begin : moved_table
      int cause;
      logic [31:0] pa;
      model(1, 'h7F, 1, cause, pa);
      chk(req_ready === 1'b1, "R3 moved table ready", 64'(req_ready), 1);
      req_valid = 1'b1; req_seg = 8'd1; req_off = 20'h7F; req_acc = 2'd1;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      chk(mem_rd_addr === 32'h0000_2008, "R3 moved table word 0 address", 64'(mem_rd_addr), 64'h2008);
      mem_rd_valid = 1'b1; mem_rd_data = dmem[2];
      @(posedge clk); @(negedge clk);
      chk(mem_rd_addr === 32'h0000_200C, "R3 moved table word 1 address", 64'(mem_rd_addr), 64'h200C);
      mem_rd_data = dmem[3];
      @(posedge clk); @(negedge clk);
      mem_rd_valid = 1'b0;
      chk(rsp_valid === 1'b1 && rsp_paddr === pa, "R7 moved table result", 64'(rsp_paddr), 64'(pa));
      @(posedge clk); @(negedge clk);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule